// File: doc/BRIEF.md
# Audio master clock rate generator

This block produces the master clock that an audio codec runs from. It is clocked at twice the oversampled port clock, which itself sits at 512 or 384 times the sample rate. Two controls set the output. A base-select bit says which of those two port rates applies. A three-bit sub-rate field then divides the port clock by a power of two. The result is a square wave at a fixed multiple of the sample rate. The legal multiples are 512, 256, 128, 64 and 32 on the 512 base, and 384, 192, 96 and 48 on the 384 base.

The output only runs while the run control is high and the gate control is low. A separate output-enable pin follows the same condition, so a pad driver can release the line. The block also reports the multiple it is currently producing, and it flags any combination of controls it cannot honour.

Configuration, run and gate changes are sampled only at an output period boundary. This keeps every start, stop and rate change free of runt pulses. The error flag is the exception: it follows the requested controls one cycle after they are presented.

Top module: `audmclk_gen`

## Requirements
- R1: While reset is held, `mclk_o`, `mclk_oe_o` and `cfg_err_o` are 0 and `ratio_o` is 0.
- R2: With `base_sel_i` = 0 (512× base) and running, sub-rate values 0, 1, 2, 3, 4 make `ratio_o` read 512, 256, 128, 64, 32.
- R3: With `base_sel_i` = 1 (384× base) and running, sub-rate values 0, 1, 2, 3 make `ratio_o` read 384, 192, 96, 48.
- R4: For an active sub-rate value k, `mclk_o` has a period of 2^(k+1) block clock cycles and is high for the first 2^k of them (50% duty).
- R5: `mclk_o` toggles and `mclk_oe_o` is 1 only while `run_i` = 1 and `gate_i` = 0; otherwise `mclk_o` and `mclk_oe_o` stay 0 and `ratio_o` reads 0.
- R6: Sub-rate values 5, 6 and 7, and value 4 with `base_sel_i` = 1, are illegal. They set `cfg_err_o` in the cycle after they are presented, and from the next period boundary on they hold `mclk_o` and `mclk_oe_o` at 0.
- R7: Changes to sub-rate, base, run and gate take effect only at a period boundary. Until then the old period completes unchanged, and every new period begins with its high half.
- R8: `cfg_err_o` follows the requested controls every cycle, independently of period boundaries. An illegal value presented just before a boundary raises the flag and drops the output enable in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the port clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_sel_i | input | 1 | 0: port clock is 512×fs, 1: 384×fs |
| mult_sel_i | input | 3 | Power-of-two sub-rate field |
| run_i | input | 1 | Run request |
| gate_i | input | 1 | Clock gate; 1 stops the output |
| mclk_o | output | 1 | Master clock to the codec |
| mclk_oe_o | output | 1 | Output enable for the master clock pad |
| ratio_o | output | 10 | Current MCLK/fs multiple, 0 when stopped |
| cfg_err_o | output | 1 | Requested controls are illegal |

## Verification
The error flag and the period boundary can land in the same cycle. That cycle is where the registered flag and the boundary-sampled enable must agree. The bench tracks the period phase in its reference model and waits until the next edge is a boundary. It then presents an illegal sub-rate, and in the following cycle it expects the flag high and the enable low together. It also swaps the sub-rate in the middle of a period and checks that the old half-period runs to completion.

// File: rtl/audmclk_pkg.sv
package audmclk_pkg;
    typedef enum logic {
        BASE_X512 = 1'b0,
        BASE_X384 = 1'b1
    } base_e;

    localparam int unsigned RATE_HI = 512;
    localparam int unsigned RATE_LO = 384;
endpackage

// File: rtl/audmclk_decode.sv
module audmclk_decode
    import audmclk_pkg::*;
#(
    parameter int FIELD_W = 3,
    parameter int MAX_HI  = 4,
    parameter int MAX_LO  = 3,
    parameter int RATIO_W = 10
) (
    input  base_e               base_i,
    input  logic [FIELD_W-1:0]  fld_i,
    output logic                legal_o,
    output logic [RATIO_W-1:0]  ratio_o
);
    localparam logic [RATIO_W-1:0] HI_BASE = RATIO_W'(RATE_HI);
    localparam logic [RATIO_W-1:0] LO_BASE = RATIO_W'(RATE_LO);

    always_comb begin
        if (base_i == BASE_X384) begin
            legal_o = (int'(fld_i) <= MAX_LO);
            ratio_o = LO_BASE >> fld_i;
        end else begin
            legal_o = (int'(fld_i) <= MAX_HI);
            ratio_o = HI_BASE >> fld_i;
        end
        if (!legal_o) begin
            ratio_o = '0;
        end
    end
endmodule

// File: rtl/audmclk_phase.sv
module audmclk_phase #(
    parameter int FIELD_W = 3,
    parameter int PH_W    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] shift_i,
    output logic [PH_W-1:0]    ph_o,
    output logic [PH_W-1:0]    ph_next_o,
    output logic               wrap_o
);
    logic [PH_W-1:0] ph_d, ph_q;
    logic [PH_W:0]   period;

    always_comb begin
        period    = (PH_W+1)'(1) << (shift_i + FIELD_W'(1));
        wrap_o    = ({1'b0, ph_q} == (period - (PH_W+1)'(1)));
        ph_d      = wrap_o ? '0 : ph_q + PH_W'(1);
        ph_next_o = ph_d;
        ph_o      = ph_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end
endmodule

// File: rtl/audmclk_gen.sv
module audmclk_gen
    import audmclk_pkg::*;
#(
    parameter int FIELD_W = 3,
    parameter int MAX_HI  = 4,
    parameter int MAX_LO  = 3,
    parameter int RATIO_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               base_sel_i,
    input  logic [FIELD_W-1:0] mult_sel_i,
    input  logic               run_i,
    input  logic               gate_i,
    output logic               mclk_o,
    output logic               mclk_oe_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               cfg_err_o
);
    localparam int PH_W = MAX_HI + 1;

    typedef struct packed {
        logic [FIELD_W-1:0] act_fld;
        logic               act_base;
        logic               on;
        logic               mclk;
        logic               err;
    } state_t;

    state_t s_d, s_q;

    logic               req_legal;
    logic [RATIO_W-1:0] req_ratio;
    logic [RATIO_W-1:0] act_ratio;
    logic               act_legal;
    logic [PH_W-1:0]    ph_now;
    logic [PH_W-1:0]    ph_next;
    logic               wrap;
    logic [PH_W-1:0]    half_next;

    audmclk_decode #(
        .FIELD_W(FIELD_W), .MAX_HI(MAX_HI), .MAX_LO(MAX_LO), .RATIO_W(RATIO_W)
    ) u_req_dec (
        .base_i (base_e'(base_sel_i)),
        .fld_i  (mult_sel_i),
        .legal_o(req_legal),
        .ratio_o(req_ratio)
    );

    audmclk_decode #(
        .FIELD_W(FIELD_W), .MAX_HI(MAX_HI), .MAX_LO(MAX_LO), .RATIO_W(RATIO_W)
    ) u_act_dec (
        .base_i (base_e'(s_q.act_base)),
        .fld_i  (s_q.act_fld),
        .legal_o(act_legal),
        .ratio_o(act_ratio)
    );

    audmclk_phase #(
        .FIELD_W(FIELD_W), .PH_W(PH_W)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_i  (s_q.act_fld),
        .ph_o     (ph_now),
        .ph_next_o(ph_next),
        .wrap_o   (wrap)
    );

    always_comb begin
        s_d     = s_q;
        s_d.err = !req_legal;
        if (wrap) begin
            if (req_legal) begin
                s_d.act_fld  = mult_sel_i;
                s_d.act_base = base_sel_i;
            end
            s_d.on = run_i && !gate_i && req_legal;
        end
        half_next = PH_W'(1) << s_d.act_fld;
        s_d.mclk  = s_d.on && (ph_next < half_next);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mclk_o    = s_q.mclk;
    assign mclk_oe_o = s_q.on;
    assign ratio_o   = (s_q.on && act_legal) ? act_ratio : '0;
    assign cfg_err_o = s_q.err;

    logic unused_ok;
    assign unused_ok = ^{req_ratio, ph_now};
endmodule

// File: rtl/audmclk_chk.sv
module audmclk_chk #(
    parameter int FIELD_W = 3,
    parameter int MAX_HI  = 4,
    parameter int MAX_LO  = 3,
    parameter int RATIO_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               base_sel,
    input logic [FIELD_W-1:0] fld,
    input logic               mclk,
    input logic               oe,
    input logic [RATIO_W-1:0] ratio,
    input logic               err
);
    // R5
    oe_gates_mclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !mclk);

    // R5
    idle_ratio_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (ratio == '0));

    // R7
    start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> mclk);

    // R7
    ratio_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio != $past(ratio)) |-> ($rose(mclk) || !oe));

    // R6
    illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(fld) > MAX_HI) || (base_sel && (int'(fld) > MAX_LO))) |=> err);

    // R2
    legal_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> ((ratio >= RATIO_W'(32)) && (ratio <= RATIO_W'(512))));
endmodule

bind audmclk_gen audmclk_chk #(
    .FIELD_W(FIELD_W), .MAX_HI(MAX_HI), .MAX_LO(MAX_LO), .RATIO_W(RATIO_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .base_sel(base_sel_i),
    .fld     (mult_sel_i),
    .mclk    (mclk_o),
    .oe      (mclk_oe_o),
    .ratio   (ratio_o),
    .err     (cfg_err_o)
);

// File: tb/audmclk_gen_bench.sv
module audmclk_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_sel = 1'b0;
    logic [2:0] fld = 3'd0;
    logic       run = 1'b0;
    logic       gate = 1'b0;
    logic       mclk, oe, err;
    logic [9:0] ratio;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string tag = "R1";

    int m_ph = 0, m_f = 0, m_b = 0, m_on = 0, m_err = 0;

    always #4 clk = ~clk;

    audmclk_gen u_audmclk_gen (
        .clk(clk), .rst_n(rst_n), .base_sel_i(base_sel), .mult_sel_i(fld),
        .run_i(run), .gate_i(gate), .mclk_o(mclk), .mclk_oe_o(oe),
        .ratio_o(ratio), .cfg_err_o(err)
    );

    function automatic int rat(int b, int f);
        return (b != 0 ? 384 : 512) >> f;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        int legal;
        @(posedge clk);
        #1;
        legal = base_sel ? (fld <= 3) : (fld <= 4);
        m_err = !legal;
        if (m_ph == (2 << m_f) - 1) begin
            if (legal) begin
                m_f = fld;
                m_b = base_sel;
            end
            m_on = run && !gate && legal;
            m_ph = 0;
        end else begin
            m_ph++;
        end
        check({tag, " mclk"}, int'(mclk), (m_on != 0 && m_ph < (1 << m_f)) ? 1 : 0);
        check({tag, " oe"}, int'(oe), m_on);
        check({tag, " ratio"}, int'(ratio), m_on != 0 ? rat(m_b, m_f) : 0);
        check({tag, " err"}, int'(err), m_err);
    endtask

    task automatic run_n(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        int highs;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 mclk", int'(mclk), 0);
        check("R1 oe", int'(oe), 0);
        check("R1 ratio", int'(ratio), 0);
        check("R1 err", int'(err), 0);
        rst_n = 1'b1;
        run_n(6);

        // R2 512 base, every legal sub-rate
        tag = "R2"; run = 1'b1;
        for (int k = 0; k <= 4; k++) begin
            fld = 3'(k);
            run_n(70);
            check("R2 ratio table", int'(ratio), 512 / (1 << k));
        end

        // R4 duty: 64 cycles at sub-rate 2 hold exactly 32 high cycles
        tag = "R4"; fld = 3'd2;
        run_n(40);
        highs = 0;
        for (int i = 0; i < 64; i++) begin
            step();
            highs += int'(mclk);
        end
        check("R4 high count", highs, 32);

        // R3 384 base
        tag = "R3"; base_sel = 1'b1;
        for (int k = 0; k <= 3; k++) begin
            fld = 3'(k);
            run_n(40);
            check("R3 ratio table", int'(ratio), 384 / (1 << k));
        end

        // R5 gate and run
        tag = "R5"; gate = 1'b1;
        run_n(40);
        check("R5 gated oe", int'(oe), 0);
        gate = 1'b0; run_n(20);
        run = 1'b0; run_n(40);
        check("R5 stopped ratio", int'(ratio), 0);
        run = 1'b1; run_n(20);

        // R6 illegal values
        tag = "R6"; base_sel = 1'b0; fld = 3'd5;
        step();
        check("R6 err after one cycle", int'(err), 1);
        run_n(40);
        check("R6 held low oe", int'(oe), 0);
        fld = 3'd7; run_n(10);
        base_sel = 1'b1; fld = 3'd4; run_n(20);
        check("R6 384 with field 4", int'(err), 1);
        fld = 3'd1; run_n(20);
        base_sel = 1'b0;

        // R7 mid-period change
        tag = "R7"; fld = 3'd3;
        run_n(40);
        while (m_ph != 2) step();
        fld = 3'd0;
        step();
        check("R7 old period kept high", int'(mclk), 1);
        check("R7 old ratio kept", int'(ratio), 64);
        run_n(30);
        check("R7 new ratio", int'(ratio), 512);

        // R8 illegal value right before a boundary
        tag = "R8"; fld = 3'd2;
        run_n(20);
        while (m_ph != (2 << m_f) - 1) step();
        fld = 3'd6;
        step();
        check("R8 err on boundary", int'(err), 1);
        check("R8 oe dropped on boundary", int'(oe), 0);
        fld = 3'd1;
        step();
        check("R8 err cleared", int'(err), 0);
        run_n(20);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule